// File: doc/BRIEF.md
# Scaled Frequency Decimal Readout

This block turns a 10-bit tuning word into the output frequency it selects, in hertz, and shows that number on five seven-segment displays. The scaling factor is 10000/1024. The block multiplies the word by the constant 10000 and drops the ten low bits of the 24-bit product. This yields a 14-bit whole-hertz value without a divider.

The 14-bit value goes to a sequential binary-to-decimal converter. The converter uses the double-dabble method: in each of 14 steps, any decimal digit of 5 or more has 3 added to it, and then the whole register shifts left by one. The five resulting digits are each mapped to an active-low segment pattern. A conversion starts by itself whenever the tuning word differs from the last word converted. A refresh input forces a new conversion of an unchanged word. The displays change only when a conversion finishes, and a one-cycle done pulse marks that moment.

Top module: `freq_readout`

## Requirements
- R1: After reset, all five displays show the digit 0 and done is low.
- R2: The displayed number equals floor(word * 10000 / 1024), which is bits 23 to 10 of the 24-bit product.
- R3: The displays carry units on seg0_o, tens on seg1_o, hundreds on seg2_o, thousands on seg3_o and ten-thousands on seg4_o. Leading zeros are shown.
- R4: A tuning word of 45 displays 00439.
- R5: A tuning word of 1023 displays 09990.
- R6: A conversion starts at the first rising edge where the idle block sees a word that differs from the last word converted. done is high during the cycle after the 15th rising edge, counting that first edge.
- R7: The displays hold their previous value while a conversion is running. They change only at the edge that raises done.
- R8: While the word is unchanged and refresh is low, no conversion starts and done stays low.
- R9: A one-cycle refresh pulse while idle starts a conversion of the current word, with the same timing and result as R6.
- R10: The segments are active-low, with bit 6 = g down to bit 0 = a. The digits 0 to 9 are 40, 79, 24, 30, 19, 12, 02, 78, 00, 10 (hex). No digit above 9 is ever produced.
- R11: done is high for exactly one cycle per conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tune_i | input | 10 | Tuning word |
| refresh_i | input | 1 | Forces a conversion of the current word when idle |
| done_o | output | 1 | One-cycle pulse when the displays are updated |
| seg0_o | output | 7 | Units display, active low, gfedcba |
| seg1_o | output | 7 | Tens display |
| seg2_o | output | 7 | Hundreds display |
| seg3_o | output | 7 | Thousands display |
| seg4_o | output | 7 | Ten-thousands display |

## Verification
The assertions assume two things about the inputs. First, the tuning word is sampled only at the edge where a conversion starts. Second, a refresh pulse that arrives during a busy conversion is simply lost, so no assertion counts refresh pulses against done pulses. To keep within these assumptions, the stimulus changes the word or pulses refresh only while the block is idle. It then holds the input steady until the done pulse appears, so every expected result placed in the queue matches exactly one conversion.

// File: rtl/freq_readout_pkg.sv
package freq_readout_pkg;
  localparam int TUNE_W  = 10;
  localparam int MULT_K  = 10000;
  localparam int MULT_W  = 14;
  localparam int DROP_W  = 10;
  localparam int NUM_DIG = 5;

  // active-low, bit 6 = g ... bit 0 = a
  function automatic logic [6:0] seg_of_digit(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'b1000000;
      4'd1: s = 7'b1111001;
      4'd2: s = 7'b0100100;
      4'd3: s = 7'b0110000;
      4'd4: s = 7'b0011001;
      4'd5: s = 7'b0010010;
      4'd6: s = 7'b0000010;
      4'd7: s = 7'b1111000;
      4'd8: s = 7'b0000000;
      4'd9: s = 7'b0010000;
      default: s = 7'b1111111;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/freq_scaler.sv
module freq_scaler #(
  parameter int TUNE_W = freq_readout_pkg::TUNE_W,
  parameter int MULT_K = freq_readout_pkg::MULT_K,
  parameter int MULT_W = freq_readout_pkg::MULT_W,
  parameter int DROP_W = freq_readout_pkg::DROP_W,
  localparam int PROD_W = TUNE_W + MULT_W,
  localparam int FREQ_W = PROD_W - DROP_W
) (
  input  logic [TUNE_W-1:0] tune_i,
  output logic [FREQ_W-1:0] freq_o
);
  function automatic logic [PROD_W-1:0] scale_mul(input logic [TUNE_W-1:0] w);
    return PROD_W'(w) * PROD_W'(MULT_K);
  endfunction

  // keep only the upper product bits: divide by 2**DROP_W
  assign freq_o = FREQ_W'(scale_mul(tune_i) >> DROP_W);
endmodule

// File: rtl/bcd_converter.sv
module bcd_converter #(
  parameter int BIN_W   = 14,
  parameter int NUM_DIG = freq_readout_pkg::NUM_DIG,
  localparam int SR_W   = NUM_DIG * 4 + BIN_W,
  localparam int CNT_W  = $clog2(BIN_W + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [BIN_W-1:0]     bin_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [NUM_DIG*4-1:0] digits_o
);
  function automatic logic [SR_W-1:0] dd_step(input logic [SR_W-1:0] s);
    logic [SR_W-1:0] t;
    t = s;
    for (int k = 0; k < NUM_DIG; k++) begin
      if (t[BIN_W + 4*k +: 4] >= 4'd5)
        t[BIN_W + 4*k +: 4] = t[BIN_W + 4*k +: 4] + 4'd3;
    end
    return t << 1;
  endfunction

  logic [SR_W-1:0]      sr_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 busy_q, done_q;
  logic [NUM_DIG*4-1:0] digits_q;
  logic [SR_W-1:0]      step_val;
  logic                 last_iter;

  assign step_val  = dd_step(sr_q);
  assign last_iter = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      digits_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        sr_q   <= {{(NUM_DIG*4){1'b0}}, bin_i};
        cnt_q  <= CNT_W'(BIN_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        sr_q  <= step_val;
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_iter) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          digits_q <= step_val[SR_W-1:BIN_W];
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign digits_o = digits_q;

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig_chk
    // R10
    digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      digits_q[4*g +: 4] <= 4'd9);
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0 && cnt_q <= CNT_W'(BIN_W)));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R6
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(busy_q));

  // R7
  display_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> $stable(digits_q));
endmodule

// File: rtl/seg_encoder.sv
module seg_encoder #(
  parameter int NUM_DIG = freq_readout_pkg::NUM_DIG
) (
  input  logic [NUM_DIG*4-1:0] digits_i,
  output logic [NUM_DIG*7-1:0] segs_o
);
  for (genvar g = 0; g < NUM_DIG; g++) begin : g_enc
    assign segs_o[7*g +: 7] = freq_readout_pkg::seg_of_digit(digits_i[4*g +: 4]);
  end
endmodule

// File: rtl/freq_readout.sv
module freq_readout #(
  parameter int TUNE_W = freq_readout_pkg::TUNE_W,
  parameter int MULT_K = freq_readout_pkg::MULT_K,
  parameter int MULT_W = freq_readout_pkg::MULT_W,
  parameter int DROP_W = freq_readout_pkg::DROP_W,
  localparam int NUM_DIG = 5,
  localparam int FREQ_W  = TUNE_W + MULT_W - DROP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TUNE_W-1:0] tune_i,
  input  logic              refresh_i,
  output logic              done_o,
  output logic [6:0]        seg0_o,
  output logic [6:0]        seg1_o,
  output logic [6:0]        seg2_o,
  output logic [6:0]        seg3_o,
  output logic [6:0]        seg4_o
);
  logic [TUNE_W-1:0]    last_tune_q;
  logic [FREQ_W-1:0]    freq_val;
  logic                 conv_busy, conv_done, conv_start, word_moved;
  logic [NUM_DIG*4-1:0] digits;
  logic [NUM_DIG*7-1:0] segs;

  assign word_moved = (tune_i != last_tune_q);
  assign conv_start = !conv_busy && (word_moved || refresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_tune_q <= '0;
    else if (conv_start) last_tune_q <= tune_i;
  end

  freq_scaler #(.TUNE_W(TUNE_W), .MULT_K(MULT_K), .MULT_W(MULT_W), .DROP_W(DROP_W))
    u_scale (.tune_i(tune_i), .freq_o(freq_val));

  bcd_converter #(.BIN_W(FREQ_W), .NUM_DIG(NUM_DIG)) u_bcd (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(conv_start), .bin_i(freq_val),
    .busy_o(conv_busy), .done_o(conv_done), .digits_o(digits));

  seg_encoder #(.NUM_DIG(NUM_DIG)) u_seg (.digits_i(digits), .segs_o(segs));

  assign done_o = conv_done;
  assign seg0_o = segs[6:0];
  assign seg1_o = segs[13:7];
  assign seg2_o = segs[20:14];
  assign seg3_o = segs[27:21];
  assign seg4_o = segs[34:28];

  // R6
  start_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_busy && word_moved) |=> conv_busy);

  // R8
  idle_when_same_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_busy && !word_moved && !refresh_i) |=> !conv_busy);

  // R9
  refresh_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_busy && refresh_i) |=> conv_busy);
endmodule

// File: tb/freq_readout_tb.sv
module freq_readout_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] tune = '0;
  logic       refresh = 1'b0;
  logic       done;
  logic [6:0] s0, s1, s2, s3, s4;

  always #10 clk = ~clk;

  freq_readout u_dut (.clk_i(clk), .rst_ni(rst_n), .tune_i(tune), .refresh_i(refresh),
    .done_o(done), .seg0_o(s0), .seg1_o(s1), .seg2_o(s2), .seg3_o(s3), .seg4_o(s4));

  logic [6:0] pat [10] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19,
                           7'h12, 7'h02, 7'h78, 7'h00, 7'h10};
  int n_cmp = 0, n_bad = 0, n_done = 0;
  int exp_q [$];
  int shown = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_disp(input int val, input string tag);
    logic [6:0] got [5];
    int v;
    got = '{s0, s1, s2, s3, s4};
    v = val;
    for (int i = 0; i < 5; i++) begin
      chk(got[i] == pat[v % 10], tag, int'(got[i]), int'(pat[v % 10]));
      v = v / 10;
    end
  endtask

  function automatic int freq_of(input int w);
    return (w * 10000) / 1024;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pop expected value on each done pulse (R2 R3 R10)
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected done", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk_disp(e, "R2/R3/R10 display");
        shown = e;
      end
    end
  end

  // driver: present a word or refresh, expect done after exactly 15 edges (R6 R7 R9)
  task automatic convert(input int w, input bit use_refresh, input string tag);
    @(negedge clk);
    if (use_refresh) refresh = 1'b1;
    else tune = 10'(w);
    exp_q.push_back(freq_of(w));
    @(negedge clk);
    refresh = 1'b0;
    for (int i = 1; i < 14; i++) @(negedge clk);
    chk(done == 1'b0, {tag, " R6 early done"}, int'(done), 0);
    chk_disp(shown, {tag, " R7 hold during conversion"});
    @(negedge clk);
    chk(done == 1'b1, {tag, " R6 done timing"}, int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R11 single pulse"}, int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1
    chk_disp(0, "R1 reset display");
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    // R8: word equals reset value, nothing starts
    repeat (30) @(negedge clk);
    chk(n_done == 0, "R8 no conversion after reset", n_done, 0);

    convert(45, 0, "R4");
    chk_disp(439, "R4 word 45");
    convert(1023, 0, "R5");
    chk_disp(9990, "R5 word 1023");

    for (int k = 0; k < 28; k++) convert(3 + 37 * k, 0, "R2 sweep");

    // R8: hold word, no new done
    d0 = n_done;
    repeat (40) @(negedge clk);
    chk(n_done == d0, "R8 unchanged word", n_done, d0);
    chk_disp(freq_of(1002), "R8 display kept");

    // R9
    convert(1002, 1, "R9 refresh");
    chk_disp(freq_of(1002), "R9 same value");

    convert(0, 0, "R2 zero");
    convert(1, 0, "R2 one");
    chk_disp(9, "R2 word 1");
    convert(512, 0, "R2 half");
    chk_disp(5000, "R2 word 512");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule